// File: doc/BRIEF.md
# VLIW Execute-Group Dispatcher

This block sits between instruction fetch and the functional units of a statically scheduled wide-issue core. Each fetch packet holds eight 32-bit instruction slots. Each slot carries a chaining bit that says whether the next slot runs in parallel with it, and a unit field, set by the compiler, that names the functional unit the instruction goes to. The dispatcher splits the packet into execute groups. It issues one group per cycle, and it drives each instruction of the group onto the port of the unit it names. The eight ports are two address adders (units 0 and 1), two multipliers (2 and 3), two ALUs (4 and 5) and two ALU/branch units (6 and 7).

A packet is loaded with a start slot. That makes it possible to enter a packet at a branch target inside it. Slots before the start slot never issue. If the start slot lies in the middle of a group, only the tail of that group issues. A group that names one unit twice is a scheduling error. The dispatcher flags that group and drops it, and issues none of its instructions. The block asks for the next packet in the cycle that the final group of the current packet goes out, so packets can follow each other with no gap.

Top module: `vliw_grp_disp`

## Requirements
- R1: After reset, and whenever no packet is held, all of `unit_valid` is low, `conflict_err` is low and `pkt_req` is high.
- R2: Slot s occupies bits [32s+31:32s] of `pkt_data`. Bit 0 of a slot is the chaining bit (1 means the next slot joins the same group). Bits [3:1] of a slot give the unit index 0..7. A group is the run of consecutive slots that begins at the current slot and ends at the first slot whose chaining bit is 0.
- R3: Slot 7 always ends its group, whatever its chaining bit. A group never continues into the next packet.
- R4: While a group issues, unit u has `unit_valid[u]` high and `unit_insn[32u+31:32u]` equal to the full 32-bit slot that names u. Units that no member names have their valid low and their payload zero.
- R5: The first group issued from a packet begins at the `pkt_start` slot captured when the packet was accepted. Slots below it never issue, and a start slot inside a group issues only that slot and the later slots of its group.
- R6: If two members of a group name the same unit, `conflict_err` is high in that cycle and no `unit_valid` is set. The group is dropped, and the next group issues in the following cycle.
- R7: While `down_ready` is low, nothing issues and `conflict_err` stays low. The packet and the slot position are held, and issue resumes where it stopped.
- R8: `pkt_req` is high when no packet is held or when the current group is the last of its packet, and it stays high while `down_ready` is low. A packet is accepted at a clock edge when `pkt_valid` and `pkt_req` are both high and either no packet is held or `down_ready` is high. The first group of the accepted packet is on the outputs in the next cycle.
- R9: When a packet is accepted in the same cycle as the last group of the previous packet issues, the new packet's first group issues in the very next cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | A fetch packet is offered |
| pkt_data | input | 256 | Eight 32-bit instruction slots, slot 0 in the low bits |
| pkt_start | input | 3 | Entry slot of the offered packet |
| down_ready | input | 1 | The functional units can take a group this cycle |
| pkt_req | output | 1 | Request for the next fetch packet |
| unit_valid | output | 8 | Per-unit instruction valid |
| unit_insn | output | 256 | Per-unit instruction payload, unit 0 in the low bits |
| conflict_err | output | 1 | The current group names one unit twice and is dropped |

## Verification
A packet accepted at one clock edge shows its first group on the unit ports in the cycle that follows. Each later group of the same packet appears exactly one edge after the group before it. A stall or a clash shows on the outputs in the same cycle as `down_ready`, because the ports are combinational from the held packet and that input. The bench therefore drives inputs just after the falling edge, lets them settle, and compares the ports within that low phase before the next rising edge. It keeps one check per cycle of the expected group sequence, so that a group that arrives one cycle early or late is caught.

// File: rtl/vgd_pkg.sv
package vgd_pkg;
  localparam int NSLOT  = 8;
  localparam int NUNIT  = 8;
  localparam int IW     = 32;
  localparam int UW     = $clog2(NUNIT);
  localparam int ULSB   = 1;
  localparam int SW     = $clog2(NSLOT);
endpackage

// File: rtl/vgd_group_scan.sv
module vgd_group_scan #(
  parameter int NSLOT = 8,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0] chain,
  input  logic [SW-1:0]    first,
  output logic [NSLOT-1:0] member,
  output logic [SW-1:0]    last,
  output logic             at_end
);
  logic run;
  logic done;

  always_comb begin
    run    = 1'b0;
    done   = 1'b0;
    member = '0;
    last   = first;
    for (int i = 0; i < NSLOT; i++) begin
      if (SW'(i) == first) run = 1'b1;
      if (run && !done) begin
        member[i] = 1'b1;
        if (!chain[i] || i == NSLOT - 1) begin
          done = 1'b1;
          last = SW'(i);
        end
      end
    end
    at_end = (last == SW'(NSLOT - 1));
  end
endmodule

// File: rtl/vgd_router.sv
module vgd_router #(
  parameter int NSLOT = 8,
  parameter int NUNIT = 8,
  parameter int IW    = 32,
  parameter int UW    = 3,
  parameter int ULSB  = 1,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic [NSLOT*IW-1:0] words,
  input  logic [NSLOT-1:0]    member,
  output logic [NUNIT-1:0]    hit,
  output logic [NUNIT*IW-1:0] routed,
  output logic                clash
);
  logic [NUNIT-1:0] dup;

  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    logic [CW-1:0] cnt;
    logic [IW-1:0] pl;
    always_comb begin
      cnt = '0;
      pl  = '0;
      for (int s = 0; s < NSLOT; s++) begin
        if (member[s] && words[s*IW+ULSB +: UW] == UW'(u)) begin
          cnt = cnt + 1'b1;
          pl  = pl | words[s*IW +: IW];
        end
      end
    end
    assign hit[u]             = (cnt != '0);
    assign dup[u]             = (cnt > CW'(1));
    assign routed[u*IW +: IW] = pl;
  end

  assign clash = |dup;
endmodule

// File: rtl/vgd_pkt_store.sv
module vgd_pkt_store #(
  parameter int NSLOT = 8,
  parameter int IW    = 32,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NSLOT*IW-1:0] ld_data,
  input  logic [SW-1:0]       ld_start,
  input  logic                advance,
  input  logic                adv_done,
  input  logic [SW-1:0]       adv_last,
  output logic                have,
  output logic [SW-1:0]       cur,
  output logic [NSLOT*IW-1:0] data
);
  logic          have_nx;
  logic [SW-1:0] cur_nx;
  logic          data_en;

  always_comb begin
    have_nx = have;
    cur_nx  = cur;
    data_en = 1'b0;
    if (load) begin
      have_nx = 1'b1;
      cur_nx  = ld_start;
      data_en = 1'b1;
    end else if (advance) begin
      if (adv_done) have_nx = 1'b0;
      else          cur_nx  = adv_last + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have <= 1'b0;
      cur  <= '0;
    end else begin
      have <= have_nx;
      cur  <= cur_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) data <= ld_data;
  end
endmodule

// File: rtl/vliw_grp_disp.sv
module vliw_grp_disp
  import vgd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_valid,
  input  logic [NSLOT*IW-1:0] pkt_data,
  input  logic [SW-1:0]       pkt_start,
  input  logic                down_ready,
  output logic                pkt_req,
  output logic [NUNIT-1:0]    unit_valid,
  output logic [NUNIT*IW-1:0] unit_insn,
  output logic                conflict_err
);
  logic                have;
  logic [SW-1:0]       cur;
  logic [NSLOT*IW-1:0] held;
  logic [NSLOT-1:0]    chain;
  logic [NSLOT-1:0]    member;
  logic [SW-1:0]       last;
  logic                at_end;
  logic [NUNIT-1:0]    hit;
  logic [NUNIT*IW-1:0] routed;
  logic                clash;
  logic                issue;
  logic                fire_ok;
  logic                load;

  for (genvar s = 0; s < NSLOT; s++) begin : g_chain
    assign chain[s] = held[s*IW];
  end

  assign issue   = have && down_ready;
  assign fire_ok = issue && !clash;
  assign pkt_req = !have || at_end;
  assign load    = pkt_valid && pkt_req && (!have || down_ready);

  vgd_pkt_store #(.NSLOT(NSLOT), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_data  (pkt_data),
    .ld_start (pkt_start),
    .advance  (issue),
    .adv_done (at_end),
    .adv_last (last),
    .have     (have),
    .cur      (cur),
    .data     (held)
  );

  vgd_group_scan #(.NSLOT(NSLOT)) u_scan (
    .chain  (chain),
    .first  (cur),
    .member (member),
    .last   (last),
    .at_end (at_end)
  );

  vgd_router #(.NSLOT(NSLOT), .NUNIT(NUNIT), .IW(IW), .UW(UW), .ULSB(ULSB)) u_route (
    .words  (held),
    .member (member),
    .hit    (hit),
    .routed (routed),
    .clash  (clash)
  );

  assign unit_valid   = hit & {NUNIT{fire_ok}};
  assign conflict_err = issue && clash;

  for (genvar u = 0; u < NUNIT; u++) begin : g_out
    assign unit_insn[u*IW +: IW] = routed[u*IW +: IW] & {IW{unit_valid[u]}};
  end
endmodule

// File: rtl/vgd_checker.sv
module vgd_checker #(
  parameter int NUNIT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pkt_valid,
  input logic             down_ready,
  input logic             pkt_req,
  input logic             have,
  input logic [NUNIT-1:0] unit_valid,
  input logic             conflict_err
);
  // R7
  stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !down_ready |-> (unit_valid == '0 && !conflict_err));

  // R6
  clash_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |-> unit_valid == '0);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_req && !down_ready && have) |=> pkt_req);

  // R1
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have |-> (pkt_req && unit_valid == '0));

  // R8
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_req && !have) |=> have);
endmodule

bind vliw_grp_disp vgd_checker #(.NUNIT(vgd_pkg::NUNIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pkt_valid    (pkt_valid),
  .down_ready   (down_ready),
  .pkt_req      (pkt_req),
  .have         (have),
  .unit_valid   (unit_valid),
  .conflict_err (conflict_err)
);

// File: tb/sim_vliw_grp_disp.sv
module sim_vliw_grp_disp;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         pkt_valid;
  logic [255:0] pkt_data;
  logic [2:0]   pkt_start;
  logic         down_ready;
  logic         pkt_req;
  logic [7:0]   unit_valid;
  logic [255:0] unit_insn;
  logic         conflict_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  vliw_grp_disp u0 (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_start(pkt_start), .down_ready(down_ready), .pkt_req(pkt_req),
    .unit_valid(unit_valid), .unit_insn(unit_insn), .conflict_err(conflict_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // units: slot 7 in the top three bits; chains: bit s for slot s
  function automatic logic [255:0] mkpkt(logic [23:0] units, logic [7:0] chains, logic [7:0] scn);
    logic [255:0] p;
    for (int s = 0; s < 8; s++)
      p[s*32 +: 32] = {scn, 16'h5A5A, s[3:0], units[s*3 +: 3], chains[s]};
    return p;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_grp(string req, logic [255:0] p, logic [7:0] smask);
    logic [7:0]   ev;
    logic [255:0] eb;
    ev = '0;
    eb = '0;
    for (int s = 0; s < 8; s++)
      if (smask[s]) begin
        ev[p[s*32+1 +: 3]] = 1'b1;
        eb[p[s*32+1 +: 3]*32 +: 32] = p[s*32 +: 32];
      end
    checks++;
    if (unit_valid !== ev || unit_insn !== eb) begin
      fails++;
      $display("FAIL %s group valid=%h expected=%h insn=%h expected=%h",
               req, unit_valid, ev, unit_insn, eb);
    end
  endtask

  task automatic offer(logic [255:0] p, logic [2:0] st);
    pkt_data  = p;
    pkt_start = st;
    pkt_valid = 1'b1;
  endtask

  // R1
  task automatic t_reset();
    #1;
    check_grp("R1", '0, 8'h00);
    check_bit("R1", "pkt_req", pkt_req, 1'b1);
    check_bit("R1", "conflict_err", conflict_err, 1'b0);
  endtask

  // R2 R3 R4: one group spans the whole packet, slot 7 chain bit set
  task automatic t_full();
    logic [255:0] p;
    p = mkpkt({3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF, 8'h11);
    offer(p, 3'd0); down_ready = 1'b1;
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R4", p, 8'hFF);
    check_bit("R3", "pkt_req on last group", pkt_req, 1'b1);
    tick(); #1;
    check_grp("R3", p, 8'h00);
  endtask

  function automatic logic [255:0] split_pkt(logic [7:0] scn);
    return mkpkt({3'd6,3'd4,3'd3,3'd1,3'd7,3'd0,3'd5,3'd2}, 8'b0111_0011, scn);
  endfunction

  // R2 R8: three groups on successive cycles
  task automatic t_split();
    logic [255:0] p;
    p = split_pkt(8'h22);
    offer(p, 3'd0);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R2", p, 8'h07);
    check_bit("R8", "pkt_req mid packet", pkt_req, 1'b0);
    tick(); #1;
    check_grp("R2", p, 8'h08);
    tick(); #1;
    check_grp("R3", p, 8'hF0);
    check_bit("R8", "pkt_req last group", pkt_req, 1'b1);
    tick(); #1;
    check_grp("R1", p, 8'h00);
  endtask

  // R5: entry inside a group
  task automatic t_mid();
    logic [255:0] p;
    p = split_pkt(8'h33);
    offer(p, 3'd1);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R5", p, 8'h06);
    tick(); #1;
    check_grp("R5", p, 8'h08);
    tick(); #1;
    check_grp("R5", p, 8'hF0);
    tick();
    offer(p, 3'd5);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R5", p, 8'hE0);
    check_bit("R5", "pkt_req tail entry", pkt_req, 1'b1);
    tick(); #1;
    check_grp("R5", p, 8'h00);
  endtask

  // R6: unit named twice
  task automatic t_conflict();
    logic [255:0] p;
    p = mkpkt({3'd6,3'd5,3'd4,3'd2,3'd1,3'd0,3'd3,3'd3}, 8'b0111_1101, 8'h44);
    offer(p, 3'd0);
    tick(); pkt_valid = 1'b0; #1;
    check_bit("R6", "conflict_err", conflict_err, 1'b1);
    check_grp("R6", p, 8'h00);
    tick(); #1;
    check_bit("R6", "conflict_err after", conflict_err, 1'b0);
    check_grp("R6", p, 8'hFC);
    tick();
  endtask

  // R7 R8: stall in mid packet and on the last group
  task automatic t_stall();
    logic [255:0] p;
    logic [255:0] q;
    p = split_pkt(8'h55);
    q = mkpkt({3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'h7F, 8'h66);
    down_ready = 1'b0;
    offer(p, 3'd0);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R7", p, 8'h00);
    check_bit("R7", "pkt_req stalled mid", pkt_req, 1'b0);
    tick(); #1;
    check_grp("R7", p, 8'h00);
    down_ready = 1'b1; #1;
    check_grp("R7", p, 8'h07);
    tick(); #1;
    check_grp("R7", p, 8'h08);
    tick();
    down_ready = 1'b0;
    offer(q, 3'd0); #1;
    check_bit("R8", "pkt_req held in stall", pkt_req, 1'b1);
    check_grp("R7", p, 8'h00);
    tick(); #1;
    check_bit("R8", "pkt_req still held", pkt_req, 1'b1);
    down_ready = 1'b1; #1;
    check_grp("R8", p, 8'hF0);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R9", q, 8'hFF);
    tick();
  endtask

  // R9: back-to-back packets
  task automatic t_b2b();
    logic [255:0] a;
    logic [255:0] b;
    a = mkpkt({3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'h7F, 8'h77);
    b = split_pkt(8'h88);
    offer(a, 3'd0);
    tick();
    offer(b, 3'd0); #1;
    check_grp("R9", a, 8'hFF);
    tick(); pkt_valid = 1'b0; #1;
    check_grp("R9", b, 8'h07);
    tick(); tick(); tick();
  endtask

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_data = '0; pkt_start = '0; down_ready = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_full();
    t_split();
    t_mid();
    t_conflict();
    t_stall();
    t_b2b();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule